// File: doc/BRIEF.md
# Sixteen-bit accumulator processor core

This block is a compact accumulator machine. It works on 16-bit words and has one accumulator, a 12-bit program counter, a sticky overflow flag and skip-based conditionals. An instruction word carries an indirect flag in its top bit (word bit 15) and a 3-bit opcode in bits 14:12. For memory-reference instructions, bits 11:0 hold the address. Opcode 111 selects the register-operate and I/O group. That group is decoded from bit 15 and from a 4-bit sub-code in bits 11:8, with an operand nibble pair in bits 7:0.

Program and data share one 4096-word address space. The low part is writable RAM, and a small read-only window holds the boot code. On reset the core starts executing at the base of that window. Data moves to and from peripherals one word at a time over a simple strobed port: a 4-bit device select, a 4-bit function code, 16-bit data in each direction, and one strobe for each direction. The memories are arrays inside the block. The surrounding environment preloads them before reset is released.

A halt instruction freezes the core until the next reset.

Top module: `wordproc_core`

## Requirements
- R1: While reset is high and after its release, `pc_o` reads the boot address (default 0xFC0), and `acc_o`, `ovf_o`, `halted`, `io_out_stb` and `io_in_stb` are zero.
- R2: Memory-reference opcodes (bits 14:12) act on word A (bits 11:0) as follows. 000 loads A into the accumulator. 001 jumps to A. 010 adds A to the accumulator. 100 ANDs A into the accumulator. 101 stores the accumulator to A.
- R3: When bit 15 of an instruction is set, the word at A is a pointer and its low 12 bits give the next address. Bits 14:12 of the pointer are ignored. If bit 15 of the pointer is set, the chain continues for any number of levels. This applies to jumps and stores as well.
- R4: Opcode 011 writes the address of the following instruction (zero-extended) into word A, continues at A+1, and clears the accumulator.
- R5: Opcode 110 increments word A, writes the result back to A, and leaves the result in the accumulator. When the result is zero, the next instruction is skipped.
- R6: The overflow flag takes the signed two's-complement overflow of opcode 010 and opcode 110, and CLA (0x73xx with bit 15 clear) clears both the flag and the accumulator. No other instruction changes the flag. SNO (0x72xx) skips the next instruction when the flag is clear.
- R7: SAZ (0x74xx) skips when the accumulator is zero. SNZ (0xF4xx) skips when it is non-zero. SAC (0xF5xx) skips when accumulator bit B is one, where B is in bits 3:0, B=0 names word bit 15 and B=15 names bit 0.
- R8: SAL (0x70xx) shifts the accumulator left by the count in bits 3:0 and fills with zeros. RAL (0xF0xx) rotates it left by that count.
- R9: CMP (0xF3xx) replaces the accumulator with its two's complement. Any operate word whose bit 15 and sub-code pair is not listed in R6–R12 leaves the accumulator, the flag and the control flow unchanged.
- R10: DOT (0x71DF) places the accumulator on `io_data_out`, the device D (bits 7:4) on `io_dev` and the function F (bits 3:0) on `io_func`, and pulses `io_out_stb` for exactly one clock. The two strobes are never high together.
- R11: DIN (0xFCDF) places D and F on `io_dev` and `io_func` and raises `io_in_stb` for one clock. The accumulator captures `io_data_in` at the end of that clock.
- R12: HLT (0x79xx) raises `halted`. After that, the program counter (pointing past the halt word), the accumulator and the I/O port stay frozen until reset.
- R13: Addresses below RAM_WORDS (default 2048) are RAM. ROM_WORDS words (default 64) from ROM_BASE are read-only, and stores to them are dropped. All other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_data_in | input | 16 | Peripheral data captured by DIN |
| io_data_out | output | 16 | Accumulator value presented by DOT |
| io_dev | output | 4 | Device select of the last I/O instruction |
| io_func | output | 4 | Function code of the last I/O instruction |
| io_out_stb | output | 1 | One-clock output strobe |
| io_in_stb | output | 1 | One-clock input strobe |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| ovf_o | output | 1 | Sticky overflow flag |
| halted | output | 1 | Core stopped by HLT |

## Verification
Most of the core's internal state becomes visible at the ports only when a program exposes it. A wrong accumulator or a wrong effective address first appears as a bad word on `io_data_out` at the next DOT. A wrong overflow flag or a wrong skip decision appears as a missing or extra output strobe a few clocks later. The stimulus programs therefore follow every arithmetic, skip and indirection step with an output instruction, and they compare the whole sequence of strobed words, including the count of words. A corrupted link word or pointer chain changes the final program counter, and that counter is checked while the core is halted.

// File: rtl/wordproc_pkg.sv
package wordproc_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    OP_LDA = 3'b000, OP_JMP = 3'b001, OP_ADD = 3'b010, OP_JSR = 3'b011,
    OP_AND = 3'b100, OP_STA = 3'b101, OP_IAS = 3'b110, OP_OPR = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_IND, ST_EXEC, ST_DIN, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    FN_PASS, FN_ADD, FN_AND, FN_INC, FN_SHL, FN_ROL, FN_NEG, FN_ZERO
  } alu_fn_e;

  // operate sub-codes (bits 11:8 of the word)
  localparam logic [3:0] SUB_SHIFT = 4'h0;
  localparam logic [3:0] SUB_DOT   = 4'h1;
  localparam logic [3:0] SUB_SNO   = 4'h2;
  localparam logic [3:0] SUB_CLR   = 4'h3;
  localparam logic [3:0] SUB_ZTST  = 4'h4;
  localparam logic [3:0] SUB_BTST  = 4'h5;
  localparam logic [3:0] SUB_HLT   = 4'h9;
  localparam logic [3:0] SUB_DIN   = 4'hC;
endpackage

// File: rtl/wordproc_alu.sv
module wordproc_alu
  import wordproc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   amt,
  output logic [W-1:0] y,
  output logic         ovf
);
  logic [2*W-1:0] rot;
  logic [W-1:0]   one;

  assign one = {{(W-1){1'b0}}, 1'b1};
  assign rot = {a, a} << amt;

  always_comb begin
    y   = b;
    ovf = 1'b0;
    unique case (fn)
      FN_PASS: y = b;
      FN_ADD: begin
        y   = a + b;
        ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
      end
      FN_AND:  y = a & b;
      FN_INC: begin
        y   = b + one;
        ovf = !b[W-1] && y[W-1];
      end
      FN_SHL:  y = a << amt;
      FN_ROL:  y = rot[2*W-1:W];
      FN_NEG:  y = ~a + one;
      FN_ZERO: y = '0;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/wordproc_mem.sv
module wordproc_mem #(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int RAM_WORDS = 2048,
  parameter int ROM_WORDS = 64,
  parameter int ROM_BASE  = 'hFC0
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int RAM_AW = $clog2(RAM_WORDS);
  localparam int ROM_AW = $clog2(ROM_WORDS);

  logic [DW-1:0] ram [RAM_WORDS];
  logic [DW-1:0] rom [ROM_WORDS];
  logic [DW-1:0] ram_q, rom_q;
  logic          sel_ram, sel_rom;
  logic          rd_in_ram, rd_in_rom, wr_in_ram;
  logic [ROM_AW-1:0] rom_off;

  initial begin
    for (int i = 0; i < ROM_WORDS; i++) rom[i] = '0;
  end

  assign rd_in_ram = int'(rd_addr) < RAM_WORDS;
  assign rd_in_rom = (int'(rd_addr) >= ROM_BASE) && (int'(rd_addr) < ROM_BASE + ROM_WORDS);
  assign wr_in_ram = int'(wr_addr) < RAM_WORDS;
  assign rom_off   = ROM_AW'(rd_addr - AW'(ROM_BASE));

  always_ff @(posedge clk) begin
    if (we && wr_in_ram) ram[wr_addr[RAM_AW-1:0]] <= wr_data;
    ram_q   <= ram[rd_addr[RAM_AW-1:0]];
    rom_q   <= rom[rom_off];
    sel_ram <= rd_in_ram;
    sel_rom <= rd_in_rom;
  end

  assign rd_data = sel_ram ? ram_q : (sel_rom ? rom_q : '0);
endmodule

// File: rtl/wordproc_core.sv
module wordproc_core
  import wordproc_pkg::*;
#(
  parameter int RAM_WORDS = 2048,
  parameter int ROM_WORDS = 64,
  parameter int ROM_BASE  = 'hFC0,
  parameter int RESET_PC  = ROM_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] io_data_in,
  output logic [WORD_W-1:0] io_data_out,
  output logic [3:0]        io_dev,
  output logic [3:0]        io_func,
  output logic              io_out_stb,
  output logic              io_in_stb,
  output logic [WORD_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ovf_o,
  output logic              halted
);
  state_e            state;
  op_e               ir_op;
  logic [ADDR_W-1:0] pc, ea, rd_addr;
  logic [WORD_W-1:0] acc, q, wr_data, alu_y;
  logic              ovf, we, alu_ovf;
  alu_fn_e           fn;
  op_e               q_op;
  logic [3:0]        q_sub;

  assign q_op  = op_e'(q[14:12]);
  assign q_sub = q[11:8];

  wordproc_mem #(
    .AW(ADDR_W), .DW(WORD_W), .RAM_WORDS(RAM_WORDS),
    .ROM_WORDS(ROM_WORDS), .ROM_BASE(ROM_BASE)
  ) u_mem (
    .clk(clk), .rd_addr(rd_addr), .rd_data(q),
    .we(we), .wr_addr(ea), .wr_data(wr_data)
  );

  wordproc_alu #(.W(WORD_W)) u_alu (
    .fn(fn), .a(acc), .b(q), .amt(q[3:0]), .y(alu_y), .ovf(alu_ovf)
  );

  // read address: program counter while fetching, operand/pointer otherwise
  always_comb begin
    rd_addr = pc;
    if (state == ST_DEC || state == ST_IND) rd_addr = q[ADDR_W-1:0];
  end

  // ALU function select
  always_comb begin
    fn = FN_PASS;
    if (state == ST_DEC && q_op == OP_OPR) begin
      if (q_sub == SUB_SHIFT) fn = q[15] ? FN_ROL : FN_SHL;
      else if (q_sub == SUB_CLR) fn = q[15] ? FN_NEG : FN_ZERO;
    end else if (state == ST_EXEC) begin
      unique case (ir_op)
        OP_ADD:  fn = FN_ADD;
        OP_AND:  fn = FN_AND;
        OP_IAS:  fn = FN_INC;
        default: fn = FN_PASS;
      endcase
    end
  end

  // store port
  always_comb begin
    we      = 1'b0;
    wr_data = acc;
    if (state == ST_EXEC) begin
      unique case (ir_op)
        OP_STA: begin we = 1'b1; wr_data = acc; end
        OP_JSR: begin we = 1'b1; wr_data = {{(WORD_W-ADDR_W){1'b0}}, pc}; end
        OP_IAS: begin we = 1'b1; wr_data = alu_y; end
        default: we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FETCH;
      pc          <= ADDR_W'(RESET_PC);
      ea          <= '0;
      ir_op       <= OP_LDA;
      acc         <= '0;
      ovf         <= 1'b0;
      halted      <= 1'b0;
      io_data_out <= '0;
      io_dev      <= '0;
      io_func     <= '0;
      io_out_stb  <= 1'b0;
      io_in_stb   <= 1'b0;
    end else begin
      io_out_stb <= 1'b0;
      io_in_stb  <= 1'b0;
      unique case (state)
        ST_FETCH: state <= ST_DEC;

        ST_DEC: begin
          ir_op <= q_op;
          pc    <= pc + ADDR_W'(1);
          state <= ST_FETCH;
          if (q_op != OP_OPR) begin
            if (q[15]) state <= ST_IND;
            else if (q_op == OP_JMP) pc <= q[ADDR_W-1:0];
            else begin
              ea    <= q[ADDR_W-1:0];
              state <= ST_EXEC;
            end
          end else begin
            unique case ({q[15], q_sub})
              {1'b0, SUB_SHIFT}, {1'b1, SUB_SHIFT}, {1'b1, SUB_CLR}: acc <= alu_y;
              {1'b0, SUB_CLR}: begin
                acc <= alu_y;
                ovf <= 1'b0;
              end
              {1'b0, SUB_DOT}: begin
                io_data_out <= acc;
                io_dev      <= q[7:4];
                io_func     <= q[3:0];
                io_out_stb  <= 1'b1;
              end
              {1'b0, SUB_SNO}:  if (!ovf) pc <= pc + ADDR_W'(2);
              {1'b0, SUB_ZTST}: if (acc == '0) pc <= pc + ADDR_W'(2);
              {1'b1, SUB_ZTST}: if (acc != '0) pc <= pc + ADDR_W'(2);
              {1'b1, SUB_BTST}: if (acc[WORD_W-1-int'(q[3:0])]) pc <= pc + ADDR_W'(2);
              {1'b0, SUB_HLT}: begin
                halted <= 1'b1;
                state  <= ST_HALT;
              end
              {1'b1, SUB_DIN}: begin
                io_dev    <= q[7:4];
                io_func   <= q[3:0];
                io_in_stb <= 1'b1;
                state     <= ST_DIN;
              end
              default: ;
            endcase
          end
        end

        ST_IND: begin
          if (!q[15]) begin
            if (ir_op == OP_JMP) begin
              pc    <= q[ADDR_W-1:0];
              state <= ST_FETCH;
            end else begin
              ea    <= q[ADDR_W-1:0];
              state <= ST_EXEC;
            end
          end
        end

        ST_EXEC: begin
          state <= ST_FETCH;
          unique case (ir_op)
            OP_LDA, OP_AND: acc <= alu_y;
            OP_ADD: begin
              acc <= alu_y;
              ovf <= alu_ovf;
            end
            OP_JSR: begin
              acc <= '0;
              pc  <= ea + ADDR_W'(1);
            end
            OP_IAS: begin
              acc <= alu_y;
              ovf <= alu_ovf;
              if (alu_y == '0) pc <= pc + ADDR_W'(1);
            end
            default: ;
          endcase
        end

        ST_DIN: begin
          acc   <= io_data_in;
          state <= ST_FETCH;
        end

        ST_HALT: state <= ST_HALT;
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign acc_o = acc;
  assign pc_o  = pc;
  assign ovf_o = ovf;

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(io_out_stb && io_in_stb));
  a_r10_out_pulse: assert property (@(posedge clk) disable iff (rst)
    io_out_stb |=> !io_out_stb);
  a_r11_din_capture: assert property (@(posedge clk) disable iff (rst)
    io_in_stb |=> (acc == $past(io_data_in)));
  a_r12_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc) && !io_out_stb && !io_in_stb));
  a_r6_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_EXEC && state != ST_DEC) |=> $stable(ovf));
  a_r4_link_jump: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && ir_op == OP_JSR) |=> (acc == '0 && pc == $past(ea) + ADDR_W'(1)));
endmodule

// File: tb/wordproc_core_test.sv
module wordproc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_data_in = 16'hBEEF;
  logic [15:0] io_data_out, acc_o;
  logic [3:0]  io_dev, io_func;
  logic        io_out_stb, io_in_stb, ovf_o, halted;
  logic [11:0] pc_o;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  logic [15:0] dot_val [64];
  logic [3:0]  dot_dev [64];
  logic [3:0]  dot_fn  [64];
  int          dot_n = 0;
  logic [3:0]  din_dev, din_fn;
  int          din_n = 0;
  logic [15:0] exp_v [64];
  int          exp_n = 0;
  logic [11:0] bp;

  wordproc_core uut (
    .clk(clk), .rst(rst), .io_data_in(io_data_in), .io_data_out(io_data_out),
    .io_dev(io_dev), .io_func(io_func), .io_out_stb(io_out_stb), .io_in_stb(io_in_stb),
    .acc_o(acc_o), .pc_o(pc_o), .ovf_o(ovf_o), .halted(halted)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (!rst && io_out_stb && dot_n < 64) begin
      dot_val[dot_n] = io_data_out;
      dot_dev[dot_n] = io_dev;
      dot_fn[dot_n]  = io_func;
      dot_n++;
    end
    if (!rst && io_in_stb) begin
      din_dev = io_dev;
      din_fn  = io_func;
      din_n++;
    end
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // encoders
  function automatic logic [15:0] mr(input logic ind, input logic [2:0] op, input logic [11:0] a);
    return {ind, op, a};
  endfunction
  function automatic logic [15:0] opr(input logic b0, input logic [3:0] sub, input logic [7:0] lo);
    return {b0, 3'b111, sub, lo};
  endfunction

  // reference model pieces
  function automatic logic [15:0] m_rol(input logic [15:0] a, input int n);
    logic [31:0] t;
    t = {a, a} << n;
    return t[31:16];
  endfunction
  function automatic logic m_addovf(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] s;
    s = a + b;
    return (a[15] == b[15]) && (s[15] != a[15]);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] w);
    uut.u_mem.ram[a[10:0]] = w;
  endtask
  task automatic emit(input logic [15:0] w);
    put(bp, w);
    bp = bp + 12'd1;
  endtask
  task automatic expect_dot(input logic [15:0] v);
    exp_v[exp_n] = v;
    exp_n++;
  endtask

  task automatic begin_test;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2048; i++) uut.u_mem.ram[i] = 16'h0000;
    dot_n = 0; din_n = 0; exp_n = 0; bp = 12'h010;
  endtask

  task automatic go(input string req);
    int t;
    @(negedge clk);
    rst = 1'b0;
    t = 0;
    while (!halted && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " halt reached"}, {15'd0, halted}, 16'h0001);
  endtask

  task automatic cmp_log(input string req);
    chk({req, " output count"}, 16'(dot_n), 16'(exp_n));
    for (int i = 0; i < exp_n && i < dot_n; i++) chk(req, dot_val[i], exp_v[i]);
  endtask

  task automatic rand_prog(input logic [15:0] a, input logic [15:0] b, input logic [15:0] m,
                           input int n, input int bsel);
    logic [15:0] s, x, c;
    logic v;
    begin_test;
    put(12'h100, a); put(12'h101, b); put(12'h102, m);
    emit(mr(0, 3'b000, 12'h100));
    emit(mr(0, 3'b010, 12'h101));
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(0, 4'h2, 8'h00));          // SNO
    emit(opr(0, 4'h1, 8'h10));
    emit(mr(0, 3'b100, 12'h102));
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(0, 4'h0, 8'(n)));          // SAL
    emit(opr(0, 4'h1, 8'h10));
    emit(mr(0, 3'b000, 12'h100));
    emit(opr(1, 4'h0, 8'(n)));          // RAL
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(1, 4'h3, 8'h00));          // CMP
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(1, 4'h5, 8'(bsel)));       // SAC
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(0, 4'h4, 8'h00));          // SAZ
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(1, 4'h7, 8'h00));          // unlisted operate
    emit(opr(0, 4'h1, 8'h10));
    emit(opr(0, 4'h9, 8'h00));          // HLT
    s = a + b; v = m_addovf(a, b);
    expect_dot(s);                      // R2 add
    if (v) expect_dot(s);               // R6 SNO
    x = s & m; expect_dot(x);           // R2 and
    expect_dot(x << n);                 // R8 shift
    expect_dot(m_rol(a, n));            // R8 rotate
    c = ~m_rol(a, n) + 16'd1; expect_dot(c);  // R9 complement
    if (!c[15 - bsel]) expect_dot(c);   // R7 SAC
    if (c != 16'h0) expect_dot(c);      // R7 SAZ
    expect_dot(c);                      // R9 no-op
    go("R2");
    cmp_log("R2/R6/R7/R8/R9 sequence");
    chk("R6 flag after add", {15'd0, ovf_o}, {15'd0, v});
  endtask

  initial begin
    logic [11:0] pc_h;
    int dn;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 64; i++) uut.u_mem.rom[i] = 16'h0000;
    uut.u_mem.rom[0] = 16'h1010;        // jump into RAM
    uut.u_mem.rom[5] = 16'h5A5A;

    // R1 reset state
    begin_test;
    chk("R1 pc", {4'd0, pc_o}, 16'h0FC0);
    chk("R1 acc", acc_o, 16'h0000);
    chk("R1 flags", {12'd0, ovf_o, halted, io_out_stb, io_in_stb}, 16'h0000);

    // directed corners then random
    rand_prog(16'h7FFF, 16'h0001, 16'hFFFF, 0, 0);
    rand_prog(16'h8000, 16'h8000, 16'h1234, 15, 15);
    rand_prog(16'h0000, 16'h0000, 16'h0000, 4, 7);
    for (int k = 0; k < 20; k++)
      rand_prog(16'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 16), int'($urandom % 16));

    // R10 device/function fields
    begin_test;
    put(12'h100, 16'hC0DE);
    emit(mr(0, 3'b000, 12'h100));
    emit(opr(0, 4'h1, 8'h35));
    emit(opr(0, 4'h9, 8'h00));
    go("R10");
    chk("R10 count", 16'(dot_n), 16'd1);
    chk("R10 data", dot_val[0], 16'hC0DE);
    chk("R10 dev", {12'd0, dot_dev[0]}, 16'h0003);
    chk("R10 func", {12'd0, dot_fn[0]}, 16'h0005);

    // R3 indirection, including pointer with high bits set and chained levels
    begin_test;
    put(12'h200, 16'h8201); put(12'h201, 16'h7300); put(12'h300, 16'h1234);
    put(12'h202, 16'h0310); put(12'h203, 16'h0030);
    emit(mr(1, 3'b000, 12'h200));
    emit(opr(0, 4'h1, 8'h00));
    emit(mr(1, 3'b101, 12'h202));
    emit(mr(0, 3'b000, 12'h310));
    emit(opr(0, 4'h1, 8'h00));
    emit(mr(1, 3'b001, 12'h203));
    emit(opr(0, 4'h1, 8'h00));
    put(12'h030, opr(0, 4'h9, 8'h00));
    expect_dot(16'h1234); expect_dot(16'h1234);
    go("R3");
    cmp_log("R3 indirect");
    chk("R3 indirect jump target", {4'd0, pc_o}, 16'h0031);

    // R4 link and return
    begin_test;
    put(12'h100, 16'h00AA);
    emit(mr(0, 3'b000, 12'h100));
    emit(mr(0, 3'b011, 12'h040));
    emit(opr(0, 4'h1, 8'h00));
    emit(opr(0, 4'h9, 8'h00));
    put(12'h041, opr(0, 4'h1, 8'h00));
    put(12'h042, mr(0, 3'b000, 12'h040));
    put(12'h043, opr(0, 4'h1, 8'h00));
    put(12'h044, mr(1, 3'b001, 12'h040));
    expect_dot(16'h0000); expect_dot(16'h0012); expect_dot(16'h0012);
    go("R4");
    cmp_log("R4 link");

    // R5 increment-and-skip, R6 flag from increment, sticky, CLA, SNO
    begin_test;
    put(12'h100, 16'hFFFE); put(12'h101, 16'h7FFF); put(12'h102, 16'h0005);
    emit(mr(0, 3'b110, 12'h100));
    emit(opr(0, 4'h1, 8'h00));
    emit(mr(0, 3'b110, 12'h100));
    emit(opr(0, 4'h1, 8'h00));
    emit(opr(0, 4'h1, 8'h00));
    emit(mr(0, 3'b110, 12'h101));
    emit(mr(0, 3'b000, 12'h102));
    emit(opr(0, 4'h2, 8'h00));
    emit(opr(0, 4'h1, 8'h00));
    emit(opr(0, 4'h3, 8'h00));
    emit(opr(0, 4'h2, 8'h00));
    emit(opr(0, 4'h1, 8'h00));
    emit(mr(0, 3'b000, 12'h100));
    emit(opr(0, 4'h1, 8'h00));
    emit(opr(0, 4'h9, 8'h00));
    expect_dot(16'hFFFF); expect_dot(16'h0000); expect_dot(16'h0005); expect_dot(16'h0000);
    go("R5");
    cmp_log("R5/R6 increment");
    chk("R6 cleared by CLA", {15'd0, ovf_o}, 16'h0000);

    // R11 input transfer and R12 halt freeze
    begin_test;
    io_data_in = 16'hBEEF;
    emit(opr(1, 4'hC, 8'h92));
    emit(opr(0, 4'h1, 8'h00));
    emit(opr(0, 4'h9, 8'h00));
    expect_dot(16'hBEEF);
    go("R11");
    cmp_log("R11 input data");
    chk("R11 strobe count", 16'(din_n), 16'd1);
    chk("R11 dev", {12'd0, din_dev}, 16'h0009);
    chk("R11 func", {12'd0, din_fn}, 16'h0002);
    pc_h = pc_o; dn = dot_n;
    io_data_in = 16'h0F0F;
    repeat (20) @(negedge clk);
    chk("R12 pc frozen", {4'd0, pc_o}, {4'd0, pc_h});
    chk("R12 pc past halt", {4'd0, pc_o}, 16'h0013);
    chk("R12 acc frozen", acc_o, 16'hBEEF);
    chk("R12 no strobes", 16'(dot_n + din_n), 16'(dn + 1));
    chk("R12 halted", {15'd0, halted}, 16'h0001);

    // R13 memory map
    begin_test;
    put(12'h100, 16'h1111);
    emit(mr(0, 3'b000, 12'h100));
    emit(mr(0, 3'b101, 12'hFC5));
    emit(mr(0, 3'b000, 12'hFC5));
    emit(opr(0, 4'h1, 8'h00));
    emit(mr(0, 3'b000, 12'h900));
    emit(opr(0, 4'h1, 8'h00));
    emit(opr(0, 4'h9, 8'h00));
    expect_dot(16'h5A5A); expect_dot(16'h0000);
    go("R13");
    cmp_log("R13 map");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule